// File: doc/BRIEF.md
# Parallel Modulo-Metric Add-Compare-Select Unit

This block is the recursion core of a 64-state Viterbi decoder for a rate 1/2, constraint-length 7 convolutional code. Each cycle that the input strobe is high, it receives four branch metrics, one for each possible pair of code bits. For every trellis state it forms two candidate path metrics, keeps the smaller one as that state's new metric, and records which predecessor won. The 64 decision bits go out as one word to a survivor memory, which is outside this block.

Path metrics are held in a fixed 12-bit width and are allowed to wrap. The Viterbi recursion keeps the spread between live metrics far below half the 12-bit range. So the sign of the wrapped difference between two candidates orders them correctly, and the unit never has to rescale, subtract a minimum, or saturate. After reset, state 0 holds metric 0 and every other state holds a configurable offset (256 by default). This makes decoding start from the all-zero encoder state.

Top module: `acs_array`

## Requirements
- R1: While reset is low and in the cycle after it, `dec_valid` is 0 and `dec_word` is all zeros. Reset also loads metric 0 into state 0 and 256 into each of the other 63 states. The decisions of the first updates after reset follow from these values.
- R2: `dec_valid` goes high exactly one clock after a cycle in which `in_valid` was high, and it is low after a cycle in which `in_valid` was low.
- R3: Bit s of `dec_word` is 1 when the odd candidate minus the even candidate, taken modulo 4096 and read as a signed 12-bit value, is negative. A tie gives 0. The new metric of state s is the winning candidate.
- R4: State s has an even predecessor (2s) mod 64 and an odd predecessor (2s+1) mod 64. A transition from predecessor p into s carries input bit u = s[5]. The code bits come from the 7-bit window w = {u, p[5:0]}: c0 is the parity of w with taps at bits 6,5,4,3,0 (octal 171), and c1 is the parity of w with taps at bits 6,4,3,1,0 (octal 133).
- R5: `bm_in[4k+3:4k]` is the unsigned branch metric for code pair k = 2·c0 + c1. Each candidate is its predecessor's metric plus the branch metric of its transition's pair.
- R6: Metrics wrap modulo 4096. Over long runs, including runs where every metric wraps several times, each decision equals the one an unbounded integer comparison of the same candidates would give.
- R7: A cycle with `in_valid` low changes no metric and leaves `dec_word` unchanged.
- R8: All 64 decision bits of one update appear together, from a register, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Branch metrics on `bm_in` are valid this cycle |
| bm_in | input | 16 | Four 4-bit branch metrics, pair k at bits 4k+3:4k |
| dec_valid | output | 1 | `dec_word` holds a new decision word |
| dec_word | output | 64 | One survivor decision per state, bit s for state s |

## Verification
Each state metric feeds two successor states one update later. A wrong metric, a miswired predecessor, or a misrouted branch metric therefore flips a bit of `dec_word` within one or two updates, and after at most six updates the error has reached every state. A sign error in the modulo compare stays hidden until metrics first wrap. For that reason, long runs compare every decision word against a bench model that uses unbounded integers. Errors in holding state during idle cycles only show on the first valid update after the gap, so gaps are placed at random.

// File: rtl/acs_pkg.sv
package acs_pkg;

    // Parity of a 32-bit vector.
    function automatic logic parity32(input logic [31:0] v);
        logic p;
        p = 1'b0;
        for (int i = 0; i < 32; i++) p ^= v[i];
        return p;
    endfunction

    // Code-bit pair {c0,c1} on the transition from predecessor (2*st+odd) mod ns
    // into state st. The window is {input bit, predecessor state}.
    function automatic logic [1:0] trans_pair(input int st, input int odd, input int ns,
                                               input int gen_a, input int gen_b);
        int pred;
        int u;
        int win;
        pred = (2 * st + odd) % ns;
        u    = st / (ns / 2);
        win  = (u * ns) | pred;
        return {parity32(32'(win & gen_a)), parity32(32'(win & gen_b))};
    endfunction

endpackage

// File: rtl/acs_bm_route.sv
module acs_bm_route #(
    parameter int NS    = 64,
    parameter int BMW   = 4,
    parameter int GEN_A = 'o171,
    parameter int GEN_B = 'o133
) (
    input  logic [4*BMW-1:0]         bm_in,
    output logic [NS-1:0][BMW-1:0]   bm_even,
    output logic [NS-1:0][BMW-1:0]   bm_odd
);
    // Pick each state's two branch metrics by fixed, elaborated wiring.
    for (genvar s = 0; s < NS; s++) begin : g_route
        localparam int PE = int'(acs_pkg::trans_pair(s, 0, NS, GEN_A, GEN_B));
        localparam int PO = int'(acs_pkg::trans_pair(s, 1, NS, GEN_A, GEN_B));
        assign bm_even[s] = bm_in[PE*BMW +: BMW];
        assign bm_odd[s]  = bm_in[PO*BMW +: BMW];
    end
endmodule

// File: rtl/acs_cell.sv
module acs_cell #(
    parameter int MW  = 12,
    parameter int BMW = 4
) (
    input  logic [MW-1:0]  metric_even,
    input  logic [MW-1:0]  metric_odd,
    input  logic [BMW-1:0] bm_even,
    input  logic [BMW-1:0] bm_odd,
    output logic [MW-1:0]  cand_even,
    output logic [MW-1:0]  cand_odd,
    output logic [MW-1:0]  metric_new,
    output logic           pick_odd
);
    logic [MW-1:0] gap;

    always_comb begin
        cand_even  = metric_even + MW'(bm_even);
        cand_odd   = metric_odd + MW'(bm_odd);
        gap        = cand_odd - cand_even;   // wraps; sign orders the pair
        pick_odd   = gap[MW-1];
        metric_new = pick_odd ? cand_odd : cand_even;
    end
endmodule

// File: rtl/acs_array.sv
module acs_array #(
    parameter int K_LEN       = 7,
    parameter int MW          = 12,
    parameter int BMW         = 4,
    parameter int INIT_OFFSET = 256,
    parameter int GEN_A       = 'o171,
    parameter int GEN_B       = 'o133
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [4*BMW-1:0]         bm_in,
    output logic                     dec_valid,
    output logic [(1<<(K_LEN-1))-1:0] dec_word
);
    localparam int NS = 1 << (K_LEN - 1);

    typedef struct packed {
        logic [NS-1:0][MW-1:0] metric;
        logic [NS-1:0]         dec;
        logic                  valid;
    } acs_state_t;

    acs_state_t st_d, st_q;

    logic [NS-1:0][BMW-1:0] bm_even, bm_odd;
    logic [NS-1:0][MW-1:0]  cand_even, cand_odd, metric_new;
    logic [NS-1:0]          pick_odd;

    function automatic acs_state_t reset_state();
        acs_state_t r;
        r = '0;
        for (int s = 1; s < NS; s++) r.metric[s] = MW'(INIT_OFFSET);
        return r;
    endfunction

    acs_bm_route #(.NS(NS), .BMW(BMW), .GEN_A(GEN_A), .GEN_B(GEN_B)) u_route (
        .bm_in   (bm_in),
        .bm_even (bm_even),
        .bm_odd  (bm_odd)
    );

    for (genvar s = 0; s < NS; s++) begin : g_cell
        localparam int PE_IDX = (2 * s) % NS;
        localparam int PO_IDX = (2 * s + 1) % NS;
        acs_cell #(.MW(MW), .BMW(BMW)) u_cell (
            .metric_even (st_q.metric[PE_IDX]),
            .metric_odd  (st_q.metric[PO_IDX]),
            .bm_even     (bm_even[s]),
            .bm_odd      (bm_odd[s]),
            .cand_even   (cand_even[s]),
            .cand_odd    (cand_odd[s]),
            .metric_new  (metric_new[s]),
            .pick_odd    (pick_odd[s])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.metric = metric_new;
            st_d.dec    = pick_odd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign dec_valid = st_q.valid;
    assign dec_word  = st_q.dec;

    // ---------------- assertions ----------------
    function automatic logic not_above(input logic [MW-1:0] a, input logic [MW-1:0] b);
        logic [MW-1:0] d;
        d = a - b;
        return d[MW-1] || (d == '0);
    endfunction

    function automatic logic in_band(input logic [MW-1:0] a, input logic [MW-1:0] b);
        logic [MW-1:0] d;
        d = a - b;
        return d[MW-1] == d[MW-2];
    endfunction

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!dec_valid && dec_word == '0));

    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> dec_valid);

    assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !dec_valid);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(st_q.metric) && $stable(dec_word)));

    for (genvar s = 0; s < NS; s++) begin : g_chk
        assert_survivor_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (not_above(st_q.metric[s], $past(cand_even[s])) &&
                          not_above(st_q.metric[s], $past(cand_odd[s]))));

        assert_metric_band_R6: assert property (@(posedge clk) disable iff (!rst_n)
            in_band(st_q.metric[s], st_q.metric[0]));
    end

endmodule

// File: tb/sim_acs_array.sv
`timescale 1ns/1ps
module sim_acs_array;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] bm_in = '0;
    logic        dec_valid;
    logic [63:0] dec_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int          m [64];
    logic [63:0] last_word;

    always #5 clk = ~clk;

    acs_array u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .bm_in     (bm_in),
        .dec_valid (dec_valid),
        .dec_word  (dec_word)
    );

    // Pair index 2*c0+c1 for the transition from (2s+odd) mod 64 into s (R4).
    function automatic int pair_of(int s, int odd);
        logic [6:0] w;
        logic c0, c1;
        w  = {s >= 32 ? 1'b1 : 1'b0, 6'((2 * s + odd) % 64)};
        c0 = w[6] ^ w[5] ^ w[4] ^ w[3] ^ w[0];
        c1 = w[6] ^ w[4] ^ w[3] ^ w[1] ^ w[0];
        return 2 * int'(c0) + int'(c1);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m[0] = 0;
        for (int s = 1; s < 64; s++) m[s] = 256;
        last_word = '0;
    endtask

    // Called at a negedge; returns at the next negedge.
    task automatic step(input int b0, input int b1, input int b2, input int b3,
                        input bit v, input string req);
        int          bm [4];
        int          nm [64];
        logic [63:0] exp;
        bm[0] = b0; bm[1] = b1; bm[2] = b2; bm[3] = b3;
        exp = last_word;
        if (v) begin
            for (int s = 0; s < 64; s++) begin
                int ce, co;
                ce = m[(2 * s) % 64]     + bm[pair_of(s, 0)];
                co = m[(2 * s + 1) % 64] + bm[pair_of(s, 1)];
                exp[s] = (co < ce);
                nm[s]  = exp[s] ? co : ce;
            end
            for (int s = 0; s < 64; s++) m[s] = nm[s];
        end
        in_valid = v;
        bm_in    = {4'(b3), 4'(b2), 4'(b1), 4'(b0)};
        @(posedge clk);
        #1;
        check("R2 dec_valid", 64'(dec_valid), 64'(v));
        if (v) check(req, dec_word, exp);
        else   check("R7 idle hold", dec_word, last_word);
        last_word = exp;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset dec_valid", 64'(dec_valid), 64'd0);
        check("R1 reset dec_word", dec_word, 64'd0);
        rst_n = 1'b1;
        model_reset();
        @(posedge clk);
        #1;
        check("R1 post-reset dec_valid", 64'(dec_valid), 64'd0);
        @(negedge clk);
    endtask

    initial begin
        logic [5:0] enc;
        model_reset();
        do_reset();

        // Initial offsets drive the first decisions.
        step(0, 5, 9, 15, 1, "R1 first update");
        step(15, 9, 5, 0, 1, "R1 second update");
        step(3, 12, 7, 1, 1, "R1 third update");

        // Sweep each pair slot over every amplitude (R5).
        for (int k = 0; k < 4; k++)
            for (int a = 1; a < 16; a++)
                step(k == 0 ? a : 0, k == 1 ? a : 0, k == 2 ? a : 0, k == 3 ? a : 0,
                     1, "R5 pair slot sweep");

        // Noiseless code sequence: metric is 5 x Hamming distance (R4).
        enc = '0;
        for (int i = 0; i < 200; i++) begin
            logic [6:0] w;
            logic u, c0, c1;
            int d [4];
            u  = 1'($urandom % 2);
            w  = {u, enc};
            c0 = w[6] ^ w[5] ^ w[4] ^ w[3] ^ w[0];
            c1 = w[6] ^ w[4] ^ w[3] ^ w[1] ^ w[0];
            for (int k = 0; k < 4; k++)
                d[k] = 5 * ((((k >> 1) & 1) != int'(c0) ? 1 : 0) + ((k & 1) != int'(c1) ? 1 : 0));
            step(d[0], d[1], d[2], d[3], 1, "R4 code sequence");
            enc = {u, enc[5:1]};
        end

        // Equal metrics: every compare ties, metrics wrap (R3, R8).
        for (int i = 0; i < 320; i++) step(15, 15, 15, 15, 1, "R3 tie and wrap, R8 word");

        // Long random run with idle gaps; metrics wrap repeatedly (R6, R7).
        for (int i = 0; i < 3000; i++) begin
            bit v;
            v = ($urandom % 5) != 0;
            step(int'($urandom % 16), int'($urandom % 16), int'($urandom % 16),
                 int'($urandom % 16), v, "R6 wrap equivalence");
        end

        // Reset in mid run restores the start state (R1).
        do_reset();
        step(2, 11, 6, 14, 1, "R1 update after re-reset");
        for (int i = 0; i < 50; i++)
            step(int'($urandom % 16), int'($urandom % 16), int'($urandom % 16),
                 int'($urandom % 16), 1, "R6 after re-reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule